// File: doc/BRIEF.md
# SMM Memory Access Router

This block sits in the memory decode path of a host bridge. It decides whether a CPU memory cycle that falls in a 64 KB system-management memory window goes to main memory (DRAM) or is passed on to the PCI bus. It also flags any cycle that hits the window as non-cacheable.

An 8-bit control register sets the behaviour. A 3-bit base field places the window in one of three spots:
- just below the top of main memory;
- the A segment (A0000h–AFFFFh);
- the B segment (B0000h–BFFFFh).

For the A and B segments, two more bits refine the routing. The open bit lets software reach SMM memory while the CPU is outside SMM, which is useful for preparing that memory before the first SMI. The close bit keeps code fetches in DRAM but sends data accesses to PCI, so SMM code can still reach a frame buffer on PCI. A sticky lock bit cancels the open bit, and only a power-on reset clears it.

The decision is combinational, from the address, the code/data strobe, the SMM-active input, the global SMRAM enable and the register contents. It is valid in the same cycle as the address. Software reaches the register through a plain write strobe and a read-data bus.

Top module: `smm_window_router`

## Requirements
- R1: After power-on reset the control register reads 00h.
- R2: Bits 7:6 of the register always read 0, and writing 1s to them has no effect on the read value or on routing.
- R3: While `smram_en` is 0, every cycle is routed to PCI (`route_pci`=1, `route_dram`=0) and `no_cache` is 0.
- R4: Base codes select the window: 3'b010 is 000A0000h–000AFFFFh, 3'b011 is 000B0000h–000BFFFFh, and 3'b000 is the 64 KB just below `mem_top_seg`×64 KB. All other codes select no window: cycles go to PCI and `no_cache` is 0. Addresses outside the selected window go to PCI with `no_cache` 0.
- R5: In the A or B window with `smm_active`=1 and close bit (bit 4) clear, both code fetches (`cpu_code`=1) and data accesses go to DRAM.
- R6: In the A or B window with the close bit set, code fetches go to DRAM and data accesses go to PCI. This applies both in SMM and when the window is open.
- R7: In the A or B window with `smm_active`=0, cycles go to PCI unless the open bit (bit 5) is effective. When it is effective, routing is as if `smm_active` were 1.
- R8: Lock (bit 3) is sticky. Writing 1 sets it, writing 0 while it is set has no effect, and only `por_n` low clears it.
- R9: While lock is set, the open bit has no routing effect, and a write cannot change a stored open bit from 0 to 1 (it may clear it).
- R10: In the top-of-memory window (base 3'b000), open and close bits are ignored. Cycles go to DRAM exactly when `smm_active`=1.
- R11: `no_cache` is 1 for every cycle that hits the selected window while `smram_en`=1, whatever the route. `route_pci` is always the complement of `route_dram`.
- R12: The routing outputs follow the inputs combinationally in the same cycle. A register write changes the read value and the routing only after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| cpu_addr | input | ADDR_W | CPU memory address |
| cpu_code | input | 1 | 1 = code fetch, 0 = data access |
| smm_active | input | 1 | CPU is in system-management mode |
| smram_en | input | 1 | Global SMRAM enable |
| mem_top_seg | input | ADDR_W-16 | Top of main memory, in 64 KB units |
| route_dram | output | 1 | Cycle goes to main memory |
| route_pci | output | 1 | Cycle goes to PCI |
| no_cache | output | 1 | Cycle hits the window and must not be cached |

## Verification
The three routing outputs are due in the same cycle as the inputs that cause them. The bench therefore drives address and control inputs away from the clock edge, waits 1 ns without an edge, and samples. A register write is due one edge later. The bench raises the strobe after a falling edge and confirms that read data and routing still show the old value before the rising edge. It then checks the new value 1 ns after that edge. Expected values come from a bench-side register model, which is updated only at that edge.

// File: rtl/smm_window_router.sv
module smm_window_router #(
  parameter int ADDR_W = 32,
  parameter int WIN_LG = 16
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     cfg_we,
  input  logic [7:0]               cfg_wdata,
  output logic [7:0]               cfg_rdata,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     cpu_code,
  input  logic                     smm_active,
  input  logic                     smram_en,
  input  logic [ADDR_W-WIN_LG-1:0] mem_top_seg,
  output logic                     route_dram,
  output logic                     route_pci,
  output logic                     no_cache
);
  localparam int SEG_W = ADDR_W - WIN_LG;
  localparam logic [SEG_W-1:0] SEG_A = SEG_W'(32'h000A0000 >> WIN_LG);
  localparam logic [SEG_W-1:0] SEG_B = SEG_W'(32'h000B0000 >> WIN_LG);

  logic       open_q, close_q, lock_q;
  logic [2:0] base_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      open_q  <= 1'b0;
      close_q <= 1'b0;
      lock_q  <= 1'b0;
      base_q  <= 3'b000;
    end else if (cfg_we) begin
      lock_q  <= lock_q | cfg_wdata[3];
      open_q  <= lock_q ? (open_q & cfg_wdata[5]) : cfg_wdata[5];
      close_q <= cfg_wdata[4];
      base_q  <= cfg_wdata[2:0];
    end
  end

  assign cfg_rdata = {2'b00, open_q, close_q, lock_q, base_q};

  logic [SEG_W-1:0] seg;
  logic             in_win, legacy, grant;
  wire              open_eff = open_q & ~lock_q;

  assign seg = cpu_addr[ADDR_W-1:WIN_LG];

  always_comb begin
    in_win = 1'b0;
    legacy = 1'b0;
    case (base_q)
      3'b000: in_win = (mem_top_seg != '0) && (seg == mem_top_seg - SEG_W'(1));
      3'b010: begin in_win = (seg == SEG_A); legacy = 1'b1; end
      3'b011: begin in_win = (seg == SEG_B); legacy = 1'b1; end
      default: in_win = 1'b0;
    endcase
  end

  always_comb begin
    if (legacy) grant = (smm_active | open_eff) & ~(close_q & ~cpu_code);
    else        grant = smm_active;
  end

  assign no_cache   = smram_en & in_win;
  assign route_dram = no_cache & grant;
  assign route_pci  = ~route_dram;

  // R8
  lock_held_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(lock_q) |-> lock_q);

  // R9
  open_blocked_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(lock_q) && !$past(open_q)) |-> !open_q);

  // R11
  dram_nc_chk: assert property (@(posedge clk) disable iff (!por_n)
    route_dram |-> no_cache);

  // R3
  disabled_chk: assert property (@(posedge clk) disable iff (!por_n)
    !smram_en |-> (route_pci && !no_cache));

  // R6
  close_data_chk: assert property (@(posedge clk) disable iff (!por_n)
    (close_q && !cpu_code && base_q[1]) |-> !route_dram);
endmodule

// File: tb/test_smm_window_router.sv
`timescale 1ns/1ps
module test_smm_window_router;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [31:0] cpu_addr = 32'h0;
  logic        cpu_code = 1'b0;
  logic        smm_active = 1'b0;
  logic        smram_en = 1'b0;
  logic [15:0] mem_top_seg = 16'h0100;
  logic        route_dram, route_pci, no_cache;

  int errs = 0;
  int checks = 0;
  logic m_open, m_close, m_lock;
  logic [2:0] m_base;

  always #2.5 clk = ~clk;

  smm_window_router i_smm_window_router (
    .clk(clk), .por_n(por_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cpu_addr(cpu_addr), .cpu_code(cpu_code),
    .smm_active(smm_active), .smram_en(smram_en), .mem_top_seg(mem_top_seg),
    .route_dram(route_dram), .route_pci(route_pci), .no_cache(no_cache));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic [31:0] a, logic en);
    logic [15:0] s = a[31:16];
    logic w;
    case (m_base)
      3'b000:  w = (mem_top_seg != 16'h0) && (s == mem_top_seg - 16'h1);
      3'b010:  w = (s == 16'h000A);
      3'b011:  w = (s == 16'h000B);
      default: w = 1'b0;
    endcase
    return en & w;
  endfunction

  function automatic logic exp_dram(logic [31:0] a, logic code, logic smm, logic en);
    if (!exp_hit(a, en)) return 1'b0;
    if (m_base == 3'b000) return smm;
    if (!(smm || (m_open && !m_lock))) return 1'b0;
    if (m_close && !code) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_reset();
    m_open = 0; m_close = 0; m_lock = 0; m_base = 0;
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk);
    m_open  = m_lock ? (m_open & v[5]) : v[5];
    m_lock  = m_lock | v[3];
    m_close = v[4];
    m_base  = v[2:0];
    #1 cfg_we = 1'b0;
  endtask

  task automatic probe(string req, logic [31:0] a, logic code, logic smm, logic en);
    logic d;
    @(negedge clk);
    cpu_addr = a; cpu_code = code; smm_active = smm; smram_en = en;
    #1;
    d = exp_dram(a, code, smm, en);
    check({req, " dram"}, {31'b0, route_dram}, {31'b0, d});
    check({req, " pci"}, {31'b0, route_pci}, {31'b0, ~d});
    check({req, " nc"}, {31'b0, no_cache}, {31'b0, exp_hit(a, en)});
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    #1 model_reset();
    check("R1 reset read", {24'b0, cfg_rdata}, 32'h00);
    @(negedge clk);
    por_n = 1'b1;
  endtask

  function automatic logic [31:0] pick_addr();
    logic [15:0] lo = 16'($urandom);
    case ($urandom % 6)
      0: return {16'h000A, lo};
      1: return {16'h000B, lo};
      2: return {16'h00FF, lo};
      3: return {16'h00FE, lo};
      4: return {16'h0009 + 16'(($urandom % 2) * 3), lo};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    #1 check("R1 reset read", {24'b0, cfg_rdata}, 32'h00);
    @(negedge clk); por_n = 1'b1;
    probe("R1 reset route", 32'h00FF1234, 1, 1, 1);

    wr(8'hC0);
    check("R2 reserved bits", {24'b0, cfg_rdata}, 32'h00);
    probe("R2 reserved routing", 32'h00FF0010, 0, 1, 1);

    wr(8'h02);
    probe("R3 disabled", 32'h000A0100, 1, 1, 0);
    probe("R3 disabled data", 32'h000AFFFF, 0, 1, 0);
    probe("R5 A code", 32'h000A0000, 1, 1, 1);
    probe("R5 A data", 32'h000AFFFF, 0, 1, 1);
    probe("R4 below A", 32'h0009FFFF, 1, 1, 1);
    probe("R4 B with A base", 32'h000B0000, 1, 1, 1);

    wr(8'h13);
    probe("R6 B code", 32'h000B8000, 1, 1, 1);
    probe("R6 B data", 32'h000B8000, 0, 1, 1);

    wr(8'h03);
    probe("R7 closed non-smm", 32'h000B0004, 1, 0, 1);
    wr(8'h23);
    probe("R7 open non-smm", 32'h000B0004, 0, 0, 1);
    wr(8'h33);
    probe("R6 open close data", 32'h000B0004, 0, 0, 1);
    probe("R6 open close code", 32'h000B0004, 1, 0, 1);

    wr(8'h30);
    probe("R10 top smm data", 32'h00FF0000, 0, 1, 1);
    probe("R10 top non-smm open", 32'h00FFFFFF, 1, 0, 1);
    probe("R4 below top", 32'h00FEFFFF, 1, 1, 1);
    probe("R4 top edge", 32'h01000000, 1, 1, 1);

    wr(8'h05);
    probe("R4 reserved A", 32'h000A0000, 1, 1, 1);
    probe("R4 reserved top", 32'h00FF0000, 1, 1, 1);

    wr(8'h02);
    @(negedge clk);
    cpu_addr = 32'h000A0040; cpu_code = 0; smm_active = 1; smram_en = 1;
    cfg_we = 1'b1; cfg_wdata = 8'h12;
    #1;
    check("R12 before edge read", {24'b0, cfg_rdata}, 32'h02);
    check("R12 before edge route", {31'b0, route_dram}, 32'h1);
    @(posedge clk);
    m_close = 1; m_base = 3'b010;
    #1 cfg_we = 1'b0;
    check("R12 after edge read", {24'b0, cfg_rdata}, 32'h12);
    check("R12 after edge route", {31'b0, route_dram}, 32'h0);

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) begin
        wr(8'($urandom) & 8'hF7);
        check("R2 random read", {24'b0, cfg_rdata},
              {24'b0, 2'b00, m_open, m_close, m_lock, m_base});
      end
      probe("R11 random", pick_addr(), 1'($urandom), 1'($urandom), ($urandom % 5) != 0);
    end

    do_por();
    wr(8'h2A);
    check("R8 lock set read", {24'b0, cfg_rdata}, 32'h2A);
    probe("R9 locked open ignored", 32'h000A1000, 1, 0, 1);
    probe("R9 locked smm still dram", 32'h000A1000, 1, 1, 1);
    wr(8'h22);
    check("R8 write zero ignored", {24'b0, cfg_rdata}, 32'h2A);
    wr(8'h02);
    check("R9 open cleared", {24'b0, cfg_rdata}, 32'h0A);
    wr(8'h22);
    check("R9 open not settable", {24'b0, cfg_rdata}, 32'h0A);
    probe("R9 locked non-smm", 32'h000A0000, 1, 0, 1);
    do_por();
    check("R8 por clears lock", {24'b0, cfg_rdata}, 32'h00);
    wr(8'h22);
    probe("R7 open after por", 32'h000A0000, 0, 0, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule